// File: doc/BRIEF.md
# Partition SAD Combiner for a 16x16 Coding Unit

This block turns the 64 partial distortion values of a 16x16 coding unit into the sum of absolute differences of every prediction-unit shape inside it. Each partial value is the distortion of one four-pixel horizontal run on one row. The array of row elements is arranged as 16 rows of four runs. Element number e covers row e/4 and pixel columns 4*(e%4) to 4*(e%4)+3. Its value sits at bits [10*e+9 : 10*e] of the input bus.

One shared tree builds every shape. It first sums eight elements into each 8x4 and 4x8 block. It then adds pairs of those into 8x8 blocks and into the 4-pixel edge strips. Pairs of 8x8 blocks make the half-unit rectangles, and two halves make the whole unit. The larger part of each asymmetric split is the whole-unit sum minus the matching edge strip. All results are registered together and share one valid flag. A motion search feeds one candidate position per cycle and picks the best vector per shape downstream.

Top module: `sad_part_tree`

## Requirements
- R1: Each of the eight 8x4 outputs (8 wide, 4 tall) equals the sum of the eight elements inside it. Index b = 2*band + side, where band 0..3 runs top to bottom and side 0 is left, 1 is right. Each value is 13 bits at bits [13*b+12 : 13*b].
- R2: Each of the eight 4x8 outputs (4 wide, 8 tall) equals the sum of its eight elements. Index b = 4*band + column, with band 0 on top and column 0..3 from left to right. Each value is 13 bits at bits [13*b+12 : 13*b].
- R3: The four 8x8 outputs, each 14 bits, follow index q = 2*row + column (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right). Each equals the pixel distortion of its quadrant.
- R4: The 16x8 outputs (index 0 top, 1 bottom) and the 8x16 outputs (index 0 left, 1 right), each 15 bits, equal the distortion of their half.
- R5: The horizontal asymmetric outputs give the top 4 rows, the bottom 12 rows, the top 12 rows and the bottom 4 rows. Each pair adds up to the whole-unit value.
- R6: The vertical asymmetric outputs give the left 4 columns, the right 12 columns, the left 12 columns and the right 4 columns. Each pair adds up to the whole-unit value.
- R7: The whole-unit output is 16 bits and never wraps. When every element is at its maximum of 1020, it reads 65280, and every other output also reads its own full-scale value.
- R8: valid_o rises exactly four clock edges after the edge that samples valid_i high. It stays high for one cycle per accepted input. Inputs on consecutive cycles come out on consecutive cycles, in order.
- R9: All result outputs keep their values in every cycle in which valid_o is low, whatever the element inputs do meanwhile.
- R10: While rst_n is low, and after an asynchronous reset in the middle of a computation, valid_o is low. No result that was in flight at the reset is ever flagged valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | The element bus holds a new candidate |
| pe_sad_i | input | 640 | 64 partial SADs, 10 bits each, element e at [10e+9:10e] |
| valid_o | output | 1 | All result outputs are valid this cycle |
| sad_8x4_o | output | 104 | Eight 8x4 block SADs, 13 bits each |
| sad_4x8_o | output | 104 | Eight 4x8 block SADs, 13 bits each |
| sad_8x8_o | output | 56 | Four 8x8 quadrant SADs, 14 bits each |
| sad_16x8_o | output | 30 | Top and bottom half SADs, 15 bits each |
| sad_8x16_o | output | 30 | Left and right half SADs, 15 bits each |
| sad_top4_o | output | 14 | Top 4-row strip |
| sad_bot12_o | output | 16 | Bottom 12 rows |
| sad_top12_o | output | 16 | Top 12 rows |
| sad_bot4_o | output | 14 | Bottom 4-row strip |
| sad_left4_o | output | 14 | Left 4-column strip |
| sad_right12_o | output | 16 | Right 12 columns |
| sad_left12_o | output | 16 | Left 12 columns |
| sad_right4_o | output | 14 | Right 4-column strip |
| sad_full_o | output | 16 | Whole 16x16 unit |

## Verification
On every cycle, the assertions check that each family of outputs adds up to the same whole-unit value. They also check that the vertical and horizontal halves agree, that the result is in range, that valid_o follows valid_i at exactly four edges, and that the outputs hold while valid_o is low. Internal consistency cannot show whether each sum covers the right pixels. Only the bench's comparison of every output against rectangle sums taken directly from pixel blocks can show that. That comparison uses zero, saturated, single-hot, checkerboard, gradient and random blocks. Back-to-back ordering and the flush of in-flight work by a reset are also shown only by the bench scenarios.

// File: rtl/sadt_pkg.sv
package sadt_pkg;
  // element array geometry of one 16x16 unit
  localparam int PE_COLS       = 4;
  localparam int PE_ROWS       = 16;
  localparam int PE_NUM        = PE_COLS * PE_ROWS;
  // an 8x4 block spans two elements across and four rows
  localparam int WIDE_PE_X     = 2;
  localparam int WIDE_ROWS     = 4;
  localparam int WIDE_PER_BAND = PE_COLS / WIDE_PE_X;
  localparam int N_WIDE        = (PE_ROWS / WIDE_ROWS) * WIDE_PER_BAND;
  // a 4x8 block spans one element across and eight rows
  localparam int TALL_ROWS     = 8;
  localparam int TALL_PER_BAND = PE_COLS;
  localparam int N_TALL        = (PE_ROWS / TALL_ROWS) * TALL_PER_BAND;
  // quadrants
  localparam int QUAD_PER_BAND = 2;
  localparam int N_QUAD        = QUAD_PER_BAND * QUAD_PER_BAND;
  // register stages from valid_i to valid_o
  localparam int PIPE_LAT      = 4;

  // edges of the unit, used to index strips, halves and remainders
  typedef enum int {
    SIDE_TOP   = 0,
    SIDE_BOT   = 1,
    SIDE_LEFT  = 2,
    SIDE_RIGHT = 3
  } side_e;
  localparam int N_SIDE = 4;

  function automatic int pe_index(input int row, input int col);
    return row * PE_COLS + col;
  endfunction
endpackage

// File: rtl/sadt_leaf.sv
// Stage 1: eight-element sums for every 8x4 and 4x8 block.
module sadt_leaf
  import sadt_pkg::*;
#(
  parameter int PE_W = 10
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [PE_NUM*PE_W-1:0]        pe_i,
  output logic [N_WIDE*(PE_W+3)-1:0]    wide_o,
  output logic [N_TALL*(PE_W+3)-1:0]    tall_o
);
  localparam int LW = PE_W + 3;

  for (genvar b = 0; b < N_WIDE; b++) begin : g_wide
    localparam int BAND = b / WIDE_PER_BAND;
    localparam int SIDE = b % WIDE_PER_BAND;
    logic [LW-1:0] sum_d;
    logic [LW-1:0] sum_q;

    always_comb begin
      sum_d = '0;
      for (int r = 0; r < WIDE_ROWS; r++) begin
        for (int k = 0; k < WIDE_PE_X; k++) begin
          sum_d = sum_d + LW'(pe_i[pe_index(BAND*WIDE_ROWS + r, SIDE*WIDE_PE_X + k)*PE_W +: PE_W]);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (en) sum_q <= sum_d;
    end

    assign wide_o[b*LW +: LW] = sum_q;
  end

  for (genvar b = 0; b < N_TALL; b++) begin : g_tall
    localparam int BAND = b / TALL_PER_BAND;
    localparam int COL  = b % TALL_PER_BAND;
    logic [LW-1:0] sum_d;
    logic [LW-1:0] sum_q;

    always_comb begin
      sum_d = '0;
      for (int r = 0; r < TALL_ROWS; r++) begin
        sum_d = sum_d + LW'(pe_i[pe_index(BAND*TALL_ROWS + r, COL)*PE_W +: PE_W]);
      end
    end

    always_ff @(posedge clk) begin
      if (en) sum_q <= sum_d;
    end

    assign tall_o[b*LW +: LW] = sum_q;
  end
endmodule

// File: rtl/sadt_mid.sv
// Stage 2: quadrants from stacked 8x4 pairs, edge strips from block pairs.
module sadt_mid
  import sadt_pkg::*;
#(
  parameter int PE_W = 10
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [N_WIDE*(PE_W+3)-1:0]    wide_i,
  input  logic [N_TALL*(PE_W+3)-1:0]    tall_i,
  output logic [N_WIDE*(PE_W+3)-1:0]    wide_o,
  output logic [N_TALL*(PE_W+3)-1:0]    tall_o,
  output logic [N_QUAD*(PE_W+4)-1:0]    quad_o,
  output logic [N_SIDE*(PE_W+4)-1:0]    strip_o
);
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;

  logic [LW-1:0] wide_a  [N_WIDE];
  logic [LW-1:0] tall_a  [N_TALL];
  logic [QW-1:0] quad_d  [N_QUAD];
  logic [QW-1:0] quad_q  [N_QUAD];
  logic [QW-1:0] strip_d [N_SIDE];
  logic [QW-1:0] strip_q [N_SIDE];
  logic [N_WIDE*LW-1:0] wide_q;
  logic [N_TALL*LW-1:0] tall_q;

  for (genvar b = 0; b < N_WIDE; b++) begin : g_uw
    assign wide_a[b] = wide_i[b*LW +: LW];
  end
  for (genvar b = 0; b < N_TALL; b++) begin : g_ut
    assign tall_a[b] = tall_i[b*LW +: LW];
  end

  always_comb begin
    for (int q = 0; q < N_QUAD; q++) begin
      quad_d[q] = QW'(wide_a[(2*(q/QUAD_PER_BAND))*WIDE_PER_BAND + q%QUAD_PER_BAND])
                + QW'(wide_a[(2*(q/QUAD_PER_BAND)+1)*WIDE_PER_BAND + q%QUAD_PER_BAND]);
    end
    strip_d[SIDE_TOP]   = QW'(wide_a[0]) + QW'(wide_a[1]);
    strip_d[SIDE_BOT]   = QW'(wide_a[N_WIDE-2]) + QW'(wide_a[N_WIDE-1]);
    strip_d[SIDE_LEFT]  = QW'(tall_a[0]) + QW'(tall_a[TALL_PER_BAND]);
    strip_d[SIDE_RIGHT] = QW'(tall_a[TALL_PER_BAND-1]) + QW'(tall_a[N_TALL-1]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      wide_q  <= wide_i;
      tall_q  <= tall_i;
      quad_q  <= quad_d;
      strip_q <= strip_d;
    end
  end

  assign wide_o = wide_q;
  assign tall_o = tall_q;
  for (genvar q = 0; q < N_QUAD; q++) begin : g_pq
    assign quad_o[q*QW +: QW] = quad_q[q];
  end
  for (genvar s = 0; s < N_SIDE; s++) begin : g_ps
    assign strip_o[s*QW +: QW] = strip_q[s];
  end
endmodule

// File: rtl/sadt_upper.sv
// Stage 3: half-unit rectangles from quadrant pairs; earlier sums delayed.
module sadt_upper
  import sadt_pkg::*;
#(
  parameter int PE_W = 10
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [N_WIDE*(PE_W+3)-1:0]    wide_i,
  input  logic [N_TALL*(PE_W+3)-1:0]    tall_i,
  input  logic [N_QUAD*(PE_W+4)-1:0]    quad_i,
  input  logic [N_SIDE*(PE_W+4)-1:0]    strip_i,
  output logic [N_WIDE*(PE_W+3)-1:0]    wide_o,
  output logic [N_TALL*(PE_W+3)-1:0]    tall_o,
  output logic [N_QUAD*(PE_W+4)-1:0]    quad_o,
  output logic [N_SIDE*(PE_W+4)-1:0]    strip_o,
  output logic [N_SIDE*(PE_W+5)-1:0]    half_o
);
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;
  localparam int HW = PE_W + 5;

  logic [QW-1:0] quad_a [N_QUAD];
  logic [HW-1:0] half_d [N_SIDE];
  logic [HW-1:0] half_q [N_SIDE];
  logic [N_WIDE*LW-1:0] wide_q;
  logic [N_TALL*LW-1:0] tall_q;
  logic [N_QUAD*QW-1:0] quad_q;
  logic [N_SIDE*QW-1:0] strip_q;

  for (genvar q = 0; q < N_QUAD; q++) begin : g_uq
    assign quad_a[q] = quad_i[q*QW +: QW];
  end

  always_comb begin
    half_d[SIDE_TOP]   = HW'(quad_a[0]) + HW'(quad_a[1]);
    half_d[SIDE_BOT]   = HW'(quad_a[2]) + HW'(quad_a[3]);
    half_d[SIDE_LEFT]  = HW'(quad_a[0]) + HW'(quad_a[2]);
    half_d[SIDE_RIGHT] = HW'(quad_a[1]) + HW'(quad_a[3]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      wide_q  <= wide_i;
      tall_q  <= tall_i;
      quad_q  <= quad_i;
      strip_q <= strip_i;
      half_q  <= half_d;
    end
  end

  assign wide_o  = wide_q;
  assign tall_o  = tall_q;
  assign quad_o  = quad_q;
  assign strip_o = strip_q;
  for (genvar s = 0; s < N_SIDE; s++) begin : g_ph
    assign half_o[s*HW +: HW] = half_q[s];
  end
endmodule

// File: rtl/sadt_out.sv
// Stage 4: whole-unit sum, asymmetric remainders, common output register.
module sadt_out
  import sadt_pkg::*;
#(
  parameter int PE_W = 10
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [N_WIDE*(PE_W+3)-1:0]    wide_i,
  input  logic [N_TALL*(PE_W+3)-1:0]    tall_i,
  input  logic [N_QUAD*(PE_W+4)-1:0]    quad_i,
  input  logic [N_SIDE*(PE_W+4)-1:0]    strip_i,
  input  logic [N_SIDE*(PE_W+5)-1:0]    half_i,
  output logic [N_WIDE*(PE_W+3)-1:0]    wide_o,
  output logic [N_TALL*(PE_W+3)-1:0]    tall_o,
  output logic [N_QUAD*(PE_W+4)-1:0]    quad_o,
  output logic [N_SIDE*(PE_W+4)-1:0]    strip_o,
  output logic [N_SIDE*(PE_W+5)-1:0]    half_o,
  output logic [N_SIDE*(PE_W+6)-1:0]    rest_o,
  output logic [PE_W+5:0]               full_o
);
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;
  localparam int HW = PE_W + 5;
  localparam int FW = PE_W + 6;

  logic [FW-1:0] full_d;
  logic [FW-1:0] full_q;
  logic [FW-1:0] rest_d [N_SIDE];
  logic [FW-1:0] rest_q [N_SIDE];
  logic [N_WIDE*LW-1:0] wide_q;
  logic [N_TALL*LW-1:0] tall_q;
  logic [N_QUAD*QW-1:0] quad_q;
  logic [N_SIDE*QW-1:0] strip_q;
  logic [N_SIDE*HW-1:0] half_q;

  always_comb begin
    full_d = FW'(half_i[SIDE_TOP*HW +: HW]) + FW'(half_i[SIDE_BOT*HW +: HW]);
    // remainder after removing the strip on side s
    for (int s = 0; s < N_SIDE; s++) begin
      rest_d[s] = full_d - FW'(strip_i[s*QW +: QW]);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      wide_q  <= wide_i;
      tall_q  <= tall_i;
      quad_q  <= quad_i;
      strip_q <= strip_i;
      half_q  <= half_i;
      full_q  <= full_d;
      rest_q  <= rest_d;
    end
  end

  assign wide_o  = wide_q;
  assign tall_o  = tall_q;
  assign quad_o  = quad_q;
  assign strip_o = strip_q;
  assign half_o  = half_q;
  assign full_o  = full_q;
  for (genvar s = 0; s < N_SIDE; s++) begin : g_pr
    assign rest_o[s*FW +: FW] = rest_q[s];
  end
endmodule

// File: rtl/sad_part_tree.sv
module sad_part_tree
  import sadt_pkg::*;
#(
  parameter int PE_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_i,
  input  logic [64*PE_W-1:0]          pe_sad_i,
  output logic                        valid_o,
  output logic [8*(PE_W+3)-1:0]       sad_8x4_o,
  output logic [8*(PE_W+3)-1:0]       sad_4x8_o,
  output logic [4*(PE_W+4)-1:0]       sad_8x8_o,
  output logic [2*(PE_W+5)-1:0]       sad_16x8_o,
  output logic [2*(PE_W+5)-1:0]       sad_8x16_o,
  output logic [PE_W+3:0]             sad_top4_o,
  output logic [PE_W+5:0]             sad_bot12_o,
  output logic [PE_W+5:0]             sad_top12_o,
  output logic [PE_W+3:0]             sad_bot4_o,
  output logic [PE_W+3:0]             sad_left4_o,
  output logic [PE_W+5:0]             sad_right12_o,
  output logic [PE_W+5:0]             sad_left12_o,
  output logic [PE_W+3:0]             sad_right4_o,
  output logic [PE_W+5:0]             sad_full_o
);
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;
  localparam int HW = PE_W + 5;
  localparam int FW = PE_W + 6;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // valid pipeline: bit k enables stage k+1
  logic [PIPE_LAT-1:0] vld_d;
  logic [PIPE_LAT-1:0] vld_q;

  always_comb begin
    vld_d = {vld_q[PIPE_LAT-2:0], valid_i};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= '0;
    else            vld_q <= vld_d;
  end

  logic [N_WIDE*LW-1:0] wide_1, wide_2, wide_3;
  logic [N_TALL*LW-1:0] tall_1, tall_2, tall_3;
  logic [N_QUAD*QW-1:0] quad_2, quad_3;
  logic [N_SIDE*QW-1:0] strip_2, strip_3, strip_4;
  logic [N_SIDE*HW-1:0] half_3, half_4;
  logic [N_SIDE*FW-1:0] rest_4;

  sadt_leaf #(.PE_W(PE_W)) u_leaf (
    .clk    (clk),
    .en     (valid_i),
    .pe_i   (pe_sad_i),
    .wide_o (wide_1),
    .tall_o (tall_1)
  );

  sadt_mid #(.PE_W(PE_W)) u_mid (
    .clk     (clk),
    .en      (vld_q[0]),
    .wide_i  (wide_1),
    .tall_i  (tall_1),
    .wide_o  (wide_2),
    .tall_o  (tall_2),
    .quad_o  (quad_2),
    .strip_o (strip_2)
  );

  sadt_upper #(.PE_W(PE_W)) u_upper (
    .clk     (clk),
    .en      (vld_q[1]),
    .wide_i  (wide_2),
    .tall_i  (tall_2),
    .quad_i  (quad_2),
    .strip_i (strip_2),
    .wide_o  (wide_3),
    .tall_o  (tall_3),
    .quad_o  (quad_3),
    .strip_o (strip_3),
    .half_o  (half_3)
  );

  sadt_out #(.PE_W(PE_W)) u_out (
    .clk     (clk),
    .en      (vld_q[2]),
    .wide_i  (wide_3),
    .tall_i  (tall_3),
    .quad_i  (quad_3),
    .strip_i (strip_3),
    .half_i  (half_3),
    .wide_o  (sad_8x4_o),
    .tall_o  (sad_4x8_o),
    .quad_o  (sad_8x8_o),
    .strip_o (strip_4),
    .half_o  (half_4),
    .rest_o  (rest_4),
    .full_o  (sad_full_o)
  );

  assign valid_o       = vld_q[PIPE_LAT-1];
  assign sad_16x8_o    = {half_4[SIDE_BOT*HW +: HW],   half_4[SIDE_TOP*HW +: HW]};
  assign sad_8x16_o    = {half_4[SIDE_RIGHT*HW +: HW], half_4[SIDE_LEFT*HW +: HW]};
  assign sad_top4_o    = strip_4[SIDE_TOP*QW +: QW];
  assign sad_bot4_o    = strip_4[SIDE_BOT*QW +: QW];
  assign sad_left4_o   = strip_4[SIDE_LEFT*QW +: QW];
  assign sad_right4_o  = strip_4[SIDE_RIGHT*QW +: QW];
  assign sad_bot12_o   = rest_4[SIDE_TOP*FW +: FW];
  assign sad_top12_o   = rest_4[SIDE_BOT*FW +: FW];
  assign sad_right12_o = rest_4[SIDE_LEFT*FW +: FW];
  assign sad_left12_o  = rest_4[SIDE_RIGHT*FW +: FW];
endmodule

// File: rtl/sad_part_tree_chk.sv
module sad_part_tree_chk #(
  parameter int PE_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_i,
  input logic                   valid_o,
  input logic [8*(PE_W+3)-1:0]  sad_8x4_o,
  input logic [8*(PE_W+3)-1:0]  sad_4x8_o,
  input logic [4*(PE_W+4)-1:0]  sad_8x8_o,
  input logic [2*(PE_W+5)-1:0]  sad_16x8_o,
  input logic [2*(PE_W+5)-1:0]  sad_8x16_o,
  input logic [PE_W+3:0]        sad_top4_o,
  input logic [PE_W+5:0]        sad_bot12_o,
  input logic [PE_W+5:0]        sad_top12_o,
  input logic [PE_W+3:0]        sad_bot4_o,
  input logic [PE_W+3:0]        sad_left4_o,
  input logic [PE_W+5:0]        sad_right12_o,
  input logic [PE_W+5:0]        sad_left12_o,
  input logic [PE_W+3:0]        sad_right4_o,
  input logic [PE_W+5:0]        sad_full_o
);
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;
  localparam int HW = PE_W + 5;
  localparam int SW = PE_W + 10;
  localparam logic [SW-1:0] FULL_MAX = SW'(64 * 4 * ((1 << (PE_W - 2)) - 1));

  logic [SW-1:0] sum_wide, sum_tall, sum_quad, sum_hz, sum_vt, full_x;
  logic          armed_q;

  always_comb begin
    sum_wide = '0;
    sum_tall = '0;
    sum_quad = '0;
    for (int b = 0; b < 8; b++) begin
      sum_wide = sum_wide + SW'(sad_8x4_o[b*LW +: LW]);
      sum_tall = sum_tall + SW'(sad_4x8_o[b*LW +: LW]);
    end
    for (int q = 0; q < 4; q++) begin
      sum_quad = sum_quad + SW'(sad_8x8_o[q*QW +: QW]);
    end
    sum_hz = SW'(sad_16x8_o[0 +: HW]) + SW'(sad_16x8_o[HW +: HW]);
    sum_vt = SW'(sad_8x16_o[0 +: HW]) + SW'(sad_8x16_o[HW +: HW]);
    full_x = SW'(sad_full_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (valid_o) armed_q <= 1'b1;
  end

  p_wide_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sum_wide == full_x);
  p_tall_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sum_tall == full_x);
  p_quad_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sum_quad == full_x);
  p_halves_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sum_hz == sum_vt);
  p_amp_rows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (SW'(sad_top4_o) + SW'(sad_bot12_o) == full_x) &&
                (SW'(sad_top12_o) + SW'(sad_bot4_o) == full_x));
  p_amp_cols_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (SW'(sad_left4_o) + SW'(sad_right12_o) == full_x) &&
                (SW'(sad_left12_o) + SW'(sad_right4_o) == full_x));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> full_x <= FULL_MAX);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ##4 valid_o);
  p_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(valid_i, 4));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !valid_o) |-> ($stable(sad_full_o) && $stable(sad_8x4_o) &&
                               $stable(sad_8x8_o) && $stable(sad_top12_o)));
endmodule

bind sad_part_tree sad_part_tree_chk #(.PE_W(PE_W)) u_chk (.*);

// File: tb/sad_part_tree_tb.sv
module sad_part_tree_tb;
  localparam int PE_W = 10;
  localparam int LW = PE_W + 3;
  localparam int QW = PE_W + 4;
  localparam int HW = PE_W + 5;
  localparam int NVEC = 10;
  // {kind[31:28], seed[27:0]}: 0 zero, 1 cur max, 2 random, 3 checker,
  // 4 single hot pixel at seed[7:0], 5 gradient, 6 ref max
  localparam logic [31:0] VEC_TBL [NVEC] = '{
    32'h0000_0000, 32'h1000_0000, 32'h6000_0000, 32'h3000_0000,
    32'h4000_0000, 32'h4000_00FF, 32'h4000_005B, 32'h2000_1234,
    32'h2ABC_DEF1, 32'h5000_0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [64*PE_W-1:0] pe_sad_i = '0;
  logic valid_o;
  logic [8*LW-1:0] sad_8x4_o, sad_4x8_o;
  logic [4*QW-1:0] sad_8x8_o;
  logic [2*HW-1:0] sad_16x8_o, sad_8x16_o;
  logic [PE_W+3:0] sad_top4_o, sad_bot4_o, sad_left4_o, sad_right4_o;
  logic [PE_W+5:0] sad_bot12_o, sad_top12_o, sad_right12_o, sad_left12_o, sad_full_o;

  int total = 0;
  int bad = 0;
  int cur_px [256];
  int ref_px [256];

  always #2 clk = ~clk;

  sad_part_tree #(.PE_W(PE_W)) u_dut (.*);

  function automatic int ad(input int i);
    return (cur_px[i] > ref_px[i]) ? cur_px[i] - ref_px[i] : ref_px[i] - cur_px[i];
  endfunction

  function automatic int rect(input int x0, input int y0, input int w, input int h);
    int s = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) s += ad(y*16 + x);
    return s;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic fill(input logic [31:0] v);
    int unsigned st = {4'h0, v[27:0]} + 1;
    for (int i = 0; i < 256; i++) begin
      case (v[31:28])
        4'd0: begin cur_px[i] = 0; ref_px[i] = 0; end
        4'd1: begin cur_px[i] = 255; ref_px[i] = 0; end
        4'd2: begin
          st = st * 1103515245 + 12345; cur_px[i] = int'((st >> 16) & 255);
          st = st * 1103515245 + 12345; ref_px[i] = int'((st >> 16) & 255);
        end
        4'd3: begin cur_px[i] = (((i % 16) + (i / 16)) % 2 == 1) ? 255 : 0; ref_px[i] = 0; end
        4'd4: begin
          cur_px[i] = (i == int'(v[7:0])) ? 255 : 100;
          ref_px[i] = (i == int'(v[7:0])) ? 0 : 100;
        end
        4'd5: begin cur_px[i] = (i % 16) * 15; ref_px[i] = (i / 16) * 15; end
        default: begin cur_px[i] = 0; ref_px[i] = 255; end
      endcase
    end
  endtask

  // behavioural row elements: four horizontally adjacent pixels each
  task automatic build_pe();
    for (int e = 0; e < 64; e++) begin
      int s = 0;
      for (int k = 0; k < 4; k++) s += ad((e / 4) * 16 + (e % 4) * 4 + k);
      pe_sad_i[e*PE_W +: PE_W] = PE_W'(s);
    end
  endtask

  task automatic check_all();
    for (int b = 0; b < 8; b++) begin
      check("R1", $sformatf("8x4[%0d]", b), int'(sad_8x4_o[b*LW +: LW]),
            rect((b % 2) * 8, (b / 2) * 4, 8, 4));
      check("R2", $sformatf("4x8[%0d]", b), int'(sad_4x8_o[b*LW +: LW]),
            rect((b % 4) * 4, (b / 4) * 8, 4, 8));
    end
    for (int q = 0; q < 4; q++)
      check("R3", $sformatf("8x8[%0d]", q), int'(sad_8x8_o[q*QW +: QW]),
            rect((q % 2) * 8, (q / 2) * 8, 8, 8));
    for (int h = 0; h < 2; h++) begin
      check("R4", $sformatf("16x8[%0d]", h), int'(sad_16x8_o[h*HW +: HW]), rect(0, h*8, 16, 8));
      check("R4", $sformatf("8x16[%0d]", h), int'(sad_8x16_o[h*HW +: HW]), rect(h*8, 0, 8, 16));
    end
    check("R5", "top4",    int'(sad_top4_o),    rect(0, 0, 16, 4));
    check("R5", "bot12",   int'(sad_bot12_o),   rect(0, 4, 16, 12));
    check("R5", "top12",   int'(sad_top12_o),   rect(0, 0, 16, 12));
    check("R5", "bot4",    int'(sad_bot4_o),    rect(0, 12, 16, 4));
    check("R6", "left4",   int'(sad_left4_o),   rect(0, 0, 4, 16));
    check("R6", "right12", int'(sad_right12_o), rect(4, 0, 12, 16));
    check("R6", "left12",  int'(sad_left12_o),  rect(0, 0, 12, 16));
    check("R6", "right4",  int'(sad_right4_o),  rect(12, 0, 4, 16));
    check("R7", "full",    int'(sad_full_o),    rect(0, 0, 16, 16));
  endtask

  // drive at a falling edge, expect valid_o at the fourth falling edge after
  task automatic apply(input logic [31:0] v);
    fill(v);
    build_pe();
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", "valid_o early", int'(valid_o), 0);
    @(negedge clk);
    check("R8", "valid_o at latency", int'(valid_o), 1);
    check_all();
    @(negedge clk);
    check("R8", "valid_o single pulse", int'(valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_a, exp_b;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "valid_o in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "valid_o after release", int'(valid_o), 0);

    // table of patterns
    for (int i = 0; i < NVEC; i++) apply(VEC_TBL[i]);

    // R7: saturated block hits the top of the range
    fill(32'h1000_0000);
    check("R7", "saturated full model", rect(0, 0, 16, 16), 65280);
    apply(32'h1000_0000);
    check("R7", "saturated full", int'(sad_full_o), 65280);
    check("R7", "saturated 4x8", int'(sad_4x8_o[0 +: LW]), 8160);

    // R9: inputs change with valid_i low, results hold
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      pe_sad_i = {20{32'h5A5A_A5A5}};
      check("R9", "valid_o idle", int'(valid_o), 0);
    end
    check_all();

    // R8: back-to-back inputs, in-order outputs
    fill(32'h2000_0777); build_pe(); exp_a = rect(0, 0, 16, 16);
    @(negedge clk); valid_i = 1'b1;
    fill(32'h2000_0999);
    @(negedge clk); build_pe(); exp_b = rect(0, 0, 16, 16);
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", "stream first valid", int'(valid_o), 1);
    check("R8", "stream first full", int'(sad_full_o), exp_a);
    @(negedge clk);
    check("R8", "stream second valid", int'(valid_o), 1);
    check("R8", "stream second full", int'(sad_full_o), exp_b);
    check_all();
    @(negedge clk);
    check("R8", "stream end", int'(valid_o), 0);

    // R10: reset in the middle of a computation flushes it
    fill(32'h2000_0555); build_pe();
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10", "valid_o after mid reset", int'(valid_o), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R10", "no flushed result", int'(valid_o), 0);
    end
    apply(32'h2000_0321);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule